// File: doc/BRIEF.md
# Indexed-Memory Bit-Manipulation Executor

This block runs the second half of a doubly prefixed bit-manipulation instruction on an 8-bit processor: once the two prefix bytes have been consumed, it takes over. It fetches a signed displacement byte at the current program counter and adds it to whichever of two 16-bit index values the caller has selected. It reads the operand byte at that effective address and only then fetches the operation byte. It then rotates, shifts, tests, clears or sets a bit of the operand, writes the result back to memory where the operation requires it, and updates the flag byte. It also reports the number of machine clock cycles that the instruction is charged.

Memory traffic goes over two byte-wide valid/ready channels. On the read channel, the block raises `rd_valid` with an address, and the byte on `rd_data` is taken in the cycle where `rd_valid` and `rd_ready` are both high. On the write channel, `wr_valid` carries an address and a data byte, and the write is accepted when `wr_ready` is high in the same cycle. While valid is high and ready is low, the block holds the address (and the write data) steady and waits, with no time limit. The caller pulses `go` while the block is idle. At the end of the instruction the block pulses `fin` for one cycle, and the program counter, flags and cycle cost are then available on the outputs.

Top module: `idx_bitop_exec`

## Requirements
- R1: After `go`, exactly three reads are made, in the order: displacement at PC, operand at the effective address, then operation byte at PC+1. `pc_out` equals PC+2 when `fin` pulses.
- R2: The effective address is the index value chosen by `use_iy` (1 selects `iy_val`, 0 selects `ix_val`) plus the displacement, sign-extended and summed modulo 2^16. All writes go to this address.
- R3: Operation bytes of the form 00ttt110 perform a rotate or shift selected by ttt: 0 RLC, 1 RRC, 2 RL, 3 RR, 4 SLA, 5 SRA, 6 SLL (shift left, bit 0 becomes 1), 7 SRL. The result is written back to the effective address and the cost is 23.
- R4: After a rotate or shift, the flag byte (bit 7 S, 6 Z, 4 H, 2 P/V, 1 N, 0 C) holds C = the bit shifted out, S = bit 7 of the result, Z = 1 if the result is zero, P/V = 1 for even parity, and H = N = 0. Bits 5 and 3 are kept.
- R5: Every operation byte 01bbbxxx, whatever the value of xxx, tests bit bbb of the operand. Z is set to the inverse of that bit, H is set to 1 and N to 0, and all other flags are kept. No write is made and the cost is 20.
- R6: Operation bytes 10bbb110 clear bit bbb and 11bbb110 set it. The modified byte is written back, the flags are unchanged and the cost is 23.
- R7: Any other operation byte (00xxxxxx, 10xxxxxx or 11xxxxxx with low three bits not 110) makes no write, leaves the flags unchanged and costs 15.
- R8: While a read or write request is stalled (valid high, ready low), the request stays valid and its address and write data stay unchanged in the next cycle.
- R9: `fin` is high for exactly one cycle per instruction. For an instruction with a write-back, `fin` comes in the cycle after the write is accepted. A `go` that arrives while an instruction is in progress is ignored.
- R10: After reset, no request is valid, `fin` is 0, and `flags_out` and `cycles` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, accepted only while idle |
| use_iy | input | 1 | 1 selects iy_val as the base, 0 selects ix_val |
| ix_val | input | 16 | First index register value |
| iy_val | input | 16 | Second index register value |
| pc_in | input | 16 | Address of the displacement byte |
| flags_in | input | 8 | Flag byte before the instruction |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read accepted; rd_data valid in this cycle |
| rd_addr | output | 16 | Read address |
| rd_data | input | 8 | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |
| fin | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Program counter after the instruction |
| flags_out | output | 8 | Flag byte after the instruction |
| cycles | output | 5 | Cycle cost charged for the instruction |

## Verification
Each of the eight shift types gets an operand that tells it apart from its neighbours: a set bit 7 or bit 0 that either wraps around, enters through carry, is copied as the sign, or is forced in as a one. Zero and even-parity results confirm Z and P/V. Bit tests are applied through several low-field aliases, on both a set and a clear bit, so that a decoder that honours only one alias, or that disturbs carry, is caught. Clear, set and unhandled encodings confirm that write-back, flags and cost all follow the class of the byte. Every other vector stalls the read and write channels, and the displacements include positive, negative, most-negative and wrapping values on both index selections.

// File: rtl/idx_bitop_pkg.sv
package idx_bitop_pkg;
  typedef enum logic [2:0] {
    CLS_SHIFT, CLS_TEST, CLS_CLEAR, CLS_SETB, CLS_NONE
  } op_class_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DISP, ST_OPND, ST_OPC, ST_EXEC, ST_WR
  } step_e;

  localparam int FL_S = 7;
  localparam int FL_Z = 6;
  localparam int FL_H = 4;
  localparam int FL_P = 2;
  localparam int FL_N = 1;
  localparam int FL_C = 0;
endpackage

// File: rtl/idx_bitop_decode.sv
module idx_bitop_decode
  import idx_bitop_pkg::*;
#(
  parameter int CYC_MIN = 15,
  parameter int CYC_TST = 20,
  parameter int CYC_RMW = 23,
  parameter int CYC_W   = 5
) (
  input  logic [7:0]       opcode,
  output op_class_e        cls,
  output logic [2:0]       sel,
  output logic             wr_en,
  output logic [CYC_W-1:0] cost
);
  logic mem_form;

  assign mem_form = (opcode[2:0] == 3'b110);
  assign sel      = opcode[5:3];

  always_comb begin
    unique case (opcode[7:6])
      2'b00:   cls = mem_form ? CLS_SHIFT : CLS_NONE;
      2'b01:   cls = CLS_TEST;
      2'b10:   cls = mem_form ? CLS_CLEAR : CLS_NONE;
      default: cls = mem_form ? CLS_SETB  : CLS_NONE;
    endcase
  end

  always_comb begin
    wr_en = 1'b0;
    cost  = CYC_W'(CYC_MIN);
    case (cls)
      CLS_SHIFT, CLS_CLEAR, CLS_SETB: begin
        wr_en = 1'b1;
        cost  = CYC_W'(CYC_RMW);
      end
      CLS_TEST: cost = CYC_W'(CYC_TST);
      default: ;
    endcase
  end

  always_comb begin
    AST_WR_COSTS_RMW: assert (!wr_en || cost == CYC_W'(CYC_RMW)); // R6
  end
endmodule

// File: rtl/idx_bitop_alu.sv
module idx_bitop_alu
  import idx_bitop_pkg::*;
(
  input  op_class_e  cls,
  input  logic [2:0] sel,
  input  logic [7:0] operand,
  input  logic [7:0] flags_in,
  output logic [7:0] result,
  output logic [7:0] flags_out
);
  logic [7:0] mask;
  logic [7:0] shifted;
  logic       cout;

  assign mask = 8'b1 << sel;

  always_comb begin
    unique case (sel)
      3'd0: begin shifted = {operand[6:0], operand[7]};       cout = operand[7]; end
      3'd1: begin shifted = {operand[0], operand[7:1]};       cout = operand[0]; end
      3'd2: begin shifted = {operand[6:0], flags_in[FL_C]};   cout = operand[7]; end
      3'd3: begin shifted = {flags_in[FL_C], operand[7:1]};   cout = operand[0]; end
      3'd4: begin shifted = {operand[6:0], 1'b0};             cout = operand[7]; end
      3'd5: begin shifted = {operand[7], operand[7:1]};       cout = operand[0]; end
      3'd6: begin shifted = {operand[6:0], 1'b1};             cout = operand[7]; end
      default: begin shifted = {1'b0, operand[7:1]};          cout = operand[0]; end
    endcase
  end

  always_comb begin
    result    = operand;
    flags_out = flags_in;
    case (cls)
      CLS_SHIFT: begin
        result          = shifted;
        flags_out[FL_S] = shifted[7];
        flags_out[FL_Z] = (shifted == 8'h00);
        flags_out[FL_H] = 1'b0;
        flags_out[FL_P] = ~^shifted;
        flags_out[FL_N] = 1'b0;
        flags_out[FL_C] = cout;
      end
      CLS_TEST: begin
        flags_out[FL_Z] = ((operand & mask) == 8'h00);
        flags_out[FL_H] = 1'b1;
        flags_out[FL_N] = 1'b0;
      end
      CLS_CLEAR: result = operand & ~mask;
      CLS_SETB:  result = operand | mask;
      default: ;
    endcase
  end
endmodule

// File: rtl/idx_bitop_exec.sv
module idx_bitop_exec
  import idx_bitop_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CYC_MIN = 15,
  parameter int CYC_TST = 20,
  parameter int CYC_RMW = 23,
  localparam int CYC_W  = $clog2(CYC_RMW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              use_iy,
  input  logic [ADDR_W-1:0] ix_val,
  input  logic [ADDR_W-1:0] iy_val,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [7:0]        flags_in,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              fin,
  output logic [ADDR_W-1:0] pc_out,
  output logic [7:0]        flags_out,
  output logic [CYC_W-1:0]  cycles
);
  localparam int EXT_W = ADDR_W - 8;

  step_e             step;
  logic [ADDR_W-1:0] pc_r, base_r, ea_r;
  logic [7:0]        opnd_r, opc_r, flg_r, res_r;
  logic [CYC_W-1:0]  cyc_r;
  logic              fin_r;

  op_class_e         dec_cls;
  logic [2:0]        dec_sel;
  logic              dec_wr;
  logic [CYC_W-1:0]  dec_cost;
  logic [7:0]        alu_res, alu_flags;
  logic [ADDR_W-1:0] disp_ext;

  idx_bitop_decode #(
    .CYC_MIN(CYC_MIN), .CYC_TST(CYC_TST), .CYC_RMW(CYC_RMW), .CYC_W(CYC_W)
  ) u_decode (
    .opcode(opc_r), .cls(dec_cls), .sel(dec_sel), .wr_en(dec_wr), .cost(dec_cost)
  );

  idx_bitop_alu u_alu (
    .cls(dec_cls), .sel(dec_sel), .operand(opnd_r), .flags_in(flg_r),
    .result(alu_res), .flags_out(alu_flags)
  );

  assign disp_ext = {{EXT_W{rd_data[7]}}, rd_data};

  assign rd_valid  = (step == ST_DISP) || (step == ST_OPND) || (step == ST_OPC);
  assign rd_addr   = (step == ST_OPND) ? ea_r : pc_r;
  assign wr_valid  = (step == ST_WR);
  assign wr_addr   = ea_r;
  assign wr_data   = res_r;
  assign fin       = fin_r;
  assign pc_out    = pc_r;
  assign flags_out = flg_r;
  assign cycles    = cyc_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step   <= ST_IDLE;
      pc_r   <= '0;
      base_r <= '0;
      ea_r   <= '0;
      opnd_r <= '0;
      opc_r  <= '0;
      flg_r  <= '0;
      res_r  <= '0;
      cyc_r  <= '0;
      fin_r  <= 1'b0;
    end else begin
      fin_r <= 1'b0;
      unique case (step)
        ST_IDLE: if (go) begin
          pc_r   <= pc_in;
          base_r <= use_iy ? iy_val : ix_val;
          flg_r  <= flags_in;
          step   <= ST_DISP;
        end
        ST_DISP: if (rd_ready) begin
          ea_r <= base_r + disp_ext;
          pc_r <= pc_r + 1'b1;
          step <= ST_OPND;
        end
        ST_OPND: if (rd_ready) begin
          opnd_r <= rd_data;
          step   <= ST_OPC;
        end
        ST_OPC: if (rd_ready) begin
          opc_r <= rd_data;
          pc_r  <= pc_r + 1'b1;
          step  <= ST_EXEC;
        end
        ST_EXEC: begin
          res_r <= alu_res;
          flg_r <= alu_flags;
          cyc_r <= dec_cost;
          if (dec_wr) begin
            step <= ST_WR;
          end else begin
            fin_r <= 1'b1;
            step  <= ST_IDLE;
          end
        end
        default: if (wr_ready) begin
          fin_r <= 1'b1;
          step  <= ST_IDLE;
        end
      endcase
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R8
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R8
  AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin); // R9
  AST_FIN_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_valid) |-> fin); // R9
endmodule

// File: tb/idx_bitop_exec_bench.sv
module idx_bitop_exec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  typedef struct packed {
    logic [15:0] pc;
    logic        sel;
    logic [15:0] ix;
    logic [15:0] iy;
    logic [7:0]  d;
    logic [7:0]  opc;
    logic [7:0]  opnd;
    logic [7:0]  fin;
    logic        wr;
    logic [7:0]  wd;
    logic [7:0]  fout;
    logic [7:0]  cyc;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'h0100, 1'b0, 16'h2000, 16'h3000, 8'h05, 8'h06, 8'h85, 8'h00, 1'b1, 8'h0B, 8'h01, 8'd23},
    '{16'h0100, 1'b1, 16'h2000, 16'h3000, 8'h05, 8'h0E, 8'h01, 8'hFF, 1'b1, 8'h80, 8'hA9, 8'd23},
    '{16'h0100, 1'b0, 16'h2000, 16'h3000, 8'hFB, 8'h16, 8'h80, 8'h00, 1'b1, 8'h00, 8'h45, 8'd23},
    '{16'h0100, 1'b1, 16'h2000, 16'h3000, 8'h80, 8'h1E, 8'h01, 8'h01, 1'b1, 8'h80, 8'h81, 8'd23},
    '{16'h0100, 1'b0, 16'hFFF0, 16'h3000, 8'h20, 8'h26, 8'h41, 8'h00, 1'b1, 8'h82, 8'h84, 8'd23},
    '{16'h0200, 1'b1, 16'h2000, 16'h0005, 8'hF0, 8'h2E, 8'h81, 8'h00, 1'b1, 8'hC0, 8'h85, 8'd23},
    '{16'h0100, 1'b0, 16'h2000, 16'h3000, 8'h7F, 8'h36, 8'h80, 8'h00, 1'b1, 8'h01, 8'h01, 8'd23},
    '{16'h0100, 1'b1, 16'h2000, 16'h3000, 8'h10, 8'h3E, 8'h81, 8'h00, 1'b1, 8'h40, 8'h01, 8'd23},
    '{16'h0100, 1'b0, 16'h2000, 16'h3000, 8'h10, 8'h7E, 8'h7F, 8'h01, 1'b0, 8'h00, 8'h51, 8'd20},
    '{16'h0100, 1'b1, 16'h2000, 16'h3000, 8'h10, 8'h40, 8'h01, 8'h42, 1'b0, 8'h00, 8'h10, 8'd20},
    '{16'h0100, 1'b0, 16'h2000, 16'h3000, 8'h10, 8'h5F, 8'hF7, 8'h00, 1'b0, 8'h00, 8'h50, 8'd20},
    '{16'h0100, 1'b1, 16'h2000, 16'h3000, 8'h10, 8'hA6, 8'hFF, 8'h5A, 1'b1, 8'hEF, 8'h5A, 8'd23},
    '{16'h0100, 1'b0, 16'h2000, 16'h3000, 8'h10, 8'hC6, 8'h00, 8'h00, 1'b1, 8'h01, 8'h00, 8'd23},
    '{16'h0100, 1'b1, 16'h2000, 16'h3000, 8'h10, 8'hFE, 8'h12, 8'h00, 1'b1, 8'h92, 8'h00, 8'd23},
    '{16'h0100, 1'b0, 16'h2000, 16'h3000, 8'h10, 8'h07, 8'h85, 8'h33, 1'b0, 8'h00, 8'h33, 8'd15},
    '{16'h0100, 1'b1, 16'h2000, 16'h3000, 8'h10, 8'h80, 8'h44, 8'hC4, 1'b0, 8'h00, 8'hC4, 8'd15}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic        use_iy = 1'b0;
  logic [15:0] ix_val = '0, iy_val = '0, pc_in = '0;
  logic [7:0]  flags_in = '0;
  logic        rd_valid, wr_valid, fin;
  logic        rd_ready = 1'b0, wr_ready = 1'b0;
  logic [15:0] rd_addr, wr_addr, pc_out;
  logic [7:0]  rd_data, wr_data, flags_out;
  logic [4:0]  cycles;

  logic [15:0] cur_pc = '0, cur_ea = '0;
  logic [7:0]  cur_d = '0, cur_opc = '0, cur_opnd = '0;
  logic        stall_en = 1'b0;
  int          stall_cnt = 0;
  int          rd_n = 0, wr_n = 0, fin_n = 0;
  logic [15:0] rd_log [3];
  logic [15:0] wr_a_log = '0;
  logic [7:0]  wr_d_log = '0;
  int          checks = 0, errors = 0;

  idx_bitop_exec u_idx_bitop_exec (
    .clk(clk), .rst_n(rst_n), .go(go), .use_iy(use_iy),
    .ix_val(ix_val), .iy_val(iy_val), .pc_in(pc_in), .flags_in(flags_in),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .fin(fin), .pc_out(pc_out), .flags_out(flags_out), .cycles(cycles)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always_comb begin
    if (rd_addr == cur_pc)              rd_data = cur_d;
    else if (rd_addr == cur_pc + 16'd1) rd_data = cur_opc;
    else if (rd_addr == cur_ea)         rd_data = cur_opnd;
    else                                rd_data = 8'hEE;
  end

  always @(negedge clk) begin
    stall_cnt = stall_cnt + 1;
    rd_ready  = !stall_en || (stall_cnt % 3 == 0);
    wr_ready  = !stall_en || (stall_cnt % 4 == 1);
    if (rd_valid && rd_ready) begin
      if (rd_n < 3) rd_log[rd_n] = rd_addr;
      rd_n = rd_n + 1;
    end
    if (wr_valid && wr_ready) begin
      wr_a_log = wr_addr;
      wr_d_log = wr_data;
      wr_n = wr_n + 1;
    end
    if (fin) fin_n = fin_n + 1;
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string cls_tag(input logic [7:0] opc);
    if (opc[7:6] == 2'b01) return "R5";
    if (opc[2:0] != 3'b110) return "R7";
    if (opc[7:6] == 2'b00) return "R3";
    return "R6";
  endfunction

  task automatic run_vec(input vec_t v, input logic stall, input logic poke);
    int waited;
    cur_pc   = v.pc;
    cur_ea   = (v.sel ? v.iy : v.ix) + {{8{v.d[7]}}, v.d};
    cur_d    = v.d;
    cur_opc  = v.opc;
    cur_opnd = v.opnd;
    rd_n = 0; wr_n = 0; fin_n = 0;
    @(negedge clk);
    stall_en = stall;
    pc_in = v.pc; use_iy = v.sel; ix_val = v.ix; iy_val = v.iy; flags_in = v.fin;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    if (poke) begin
      @(negedge clk);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
    end
    waited = 0;
    while (fin_n == 0 && waited < 200) begin
      @(negedge clk);
      waited = waited + 1;
    end
    if (fin_n == 0) begin
      errors = errors + 1;
      $display("FAIL R9: watchdog, actual no fin expected fin");
    end
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_vec(input vec_t v);
    string t;
    t = cls_tag(v.opc);
    check("R1 read count", 16'(rd_n), 16'd3);
    check("R1 disp addr", rd_log[0], v.pc);
    check("R2 operand addr", rd_log[1], cur_ea);
    check("R1 opcode addr", rd_log[2], v.pc + 16'd1);
    check("R1 pc_out", pc_out, v.pc + 16'd2);
    check("R9 single fin", 16'(fin_n), 16'd1);
    check({t, " write count"}, 16'(wr_n), {15'd0, v.wr});
    if (v.wr) begin
      check("R2 write addr", wr_a_log, cur_ea);
      check({t, " write data"}, {8'd0, wr_d_log}, {8'd0, v.wd});
    end
    check({(t == "R3") ? "R4" : t, " flags"}, {8'd0, flags_out}, {8'd0, v.fout});
    check({t, " cycles"}, {11'd0, cycles}, {8'd0, v.cyc});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 rd_valid", {15'd0, rd_valid}, 16'd0);
    check("R10 wr_valid", {15'd0, wr_valid}, 16'd0);
    check("R10 fin", {15'd0, fin}, 16'd0);
    check("R10 flags_out", {8'd0, flags_out}, 16'd0);
    check("R10 cycles", {11'd0, cycles}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], i[0], 1'b0);
      check_vec(VECS[i]);
    end

    // R9: a second go while busy is ignored; R8 under stall with write-back
    run_vec(VECS[12], 1'b1, 1'b1);
    check_vec(VECS[12]);
    // R8: stalled unhandled encoding still completes with no write
    run_vec(VECS[15], 1'b1, 1'b1);
    check_vec(VECS[15]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors = errors + 1;
    $display("FAIL R9: global watchdog, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule